// File: doc/BRIEF.md
# Vertex-Priority Shader Batch Scheduler

This block hands ready batches of work to a pool of shader processors. Two producers offer batches through valid/ready handshakes. The vertex producer offers batches of 16 vertices' attributes. The fragment producer offers batches of four quads of four pixels each, 16 pixels in all. The scheduler keeps a busy bit for each processor. Each cycle it picks the lowest-numbered idle processor and gives it a vertex batch when one is offered. It takes a fragment batch only when no vertex batch is waiting.

Each accepted batch produces a one-cycle assignment record. The record carries the processor index, the slice that holds the processor, the batch kind, the batch handle and the number of work items in the batch. A processor reports the end of its shading work with a one-cycle done pulse, which returns it to the idle pool. Processors sit in slices of `PROC_PER_SLICE`, and the pool may cover several slices.

A three-state pool controller decides whether either producer may be accepted:
- **POOL_INIT** is the first cycle after reset, when nothing is accepted. It always moves to POOL_OPEN.
- **POOL_OPEN** means at least one processor is idle. It moves to POOL_FULL when the busy mask for the next cycle is all ones.
- **POOL_FULL** means every processor is busy and both ready outputs are low. It moves back to POOL_OPEN as soon as a done pulse frees a processor.

Top module: `shader_batch_sched`

## Requirements
- R1: While reset is held, every busy bit is clear and `asg_valid` is low. In the first cycle after reset is released (POOL_INIT), both `vtx_ready` and `frg_ready` are low.
- R2: An accepted vertex batch goes to the lowest-numbered idle processor. On the clock edge that accepts it, `asg_valid` rises, `asg_kind` becomes 0 (vertex) and `asg_handle` takes the batch handle.
- R3: While a vertex batch is offered and a processor is idle, `vtx_ready` is high and `frg_ready` is low, whatever the fragment producer offers.
- R4: A fragment batch is accepted only in a cycle with `vtx_valid` low. Its assignment carries `asg_kind` = 1 (fragment).
- R5: Fragment batches are assigned in the order they arrive, each one to the lowest-numbered processor that is idle at that time.
- R6: `asg_items` is `VTX_PER_BATCH` (16) for a vertex batch and `QUADS_PER_BATCH*PIX_PER_QUAD` (16) for a fragment batch.
- R7: `asg_slice` equals `asg_proc / PROC_PER_SLICE`. With the default of 2 processors per slice, processor 2 is in slice 1.
- R8: The busy bit of the assigned processor rises on the same edge that raises `asg_valid`.
- R9: When all processors are busy (POOL_FULL), both ready outputs are low, no assignment is issued, and offered batches wait.
- R10: A done pulse on a busy processor clears its busy bit at the next edge, and the processor can be chosen in the cycle after that. A done pulse on an idle processor changes nothing.
- R11: At most one batch is accepted per cycle, and `asg_valid` is high for exactly one cycle for each accepted batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vtx_valid | input | 1 | A vertex batch is offered |
| vtx_handle | input | HANDLE_W | Handle of the offered vertex batch |
| vtx_ready | output | 1 | Vertex batch accepted this cycle if valid |
| frg_valid | input | 1 | A fragment batch is offered |
| frg_handle | input | HANDLE_W | Handle of the offered fragment batch |
| frg_ready | output | 1 | Fragment batch accepted this cycle if valid |
| proc_done | input | NUM_PROC | One-cycle done pulse from each processor |
| proc_busy | output | NUM_PROC | Busy bit for each processor |
| asg_valid | output | 1 | Assignment record valid for one cycle |
| asg_proc | output | IDX_W | Index of the assigned processor |
| asg_slice | output | SLICE_W | Slice holding the assigned processor |
| asg_kind | output | 1 | 0 = vertex batch, 1 = fragment batch |
| asg_handle | output | HANDLE_W | Handle of the assigned batch |
| asg_items | output | ITEM_W | Work items in the assigned batch |

## Verification
The ready outputs depend combinationally on the offered valids and on registered state, so the bench checks them in the same cycle the stimulus is driven, 1 ns after the falling edge. The assignment record and the new busy bit appear one rising edge after the accepting cycle, so the bench checks them at the next falling edge. A done pulse clears its busy bit at one edge, and the freed processor can be picked in the cycle after that. The done-pulse tests therefore offer a batch only after that edge and check which processor receives it. Every check is made at a falling edge, half a period away from the edge that changed the value.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        POOL_INIT = 2'd0,
        POOL_OPEN = 2'd1,
        POOL_FULL = 2'd2
    } pool_state_e;

    typedef enum logic {
        KIND_VTX = 1'b0,
        KIND_FRG = 1'b1
    } batch_kind_e;

endpackage

// File: rtl/sbs_idle_pick.sv
module sbs_idle_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     idle,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest index wins: scan from the top down so the last hit is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (idle[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R2
    enc_hits_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> idle[idx]);

    // R2
    enc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((idle & ((N'(1) << idx) - N'(1))) == '0));

endmodule

// File: rtl/sbs_busy_track.sv
module sbs_busy_track #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant_vec,
    input  logic [N-1:0] done_vec,
    output logic [N-1:0] busy_q,
    output logic [N-1:0] busy_next
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            always_comb begin
                if (grant_vec[g])
                    busy_next[g] = 1'b1;
                else if (done_vec[g])
                    busy_next[g] = 1'b0;
                else
                    busy_next[g] = busy_q[g];
            end

            always_ff @(posedge clk) begin
                if (!rst_n)
                    busy_q[g] <= 1'b0;
                else
                    busy_q[g] <= busy_next[g];
            end

            // R8
            rise_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(busy_q[g]) |-> $past(grant_vec[g]));

            // R10
            fall_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy_q[g]) |-> $past(done_vec[g]));
        end
    endgenerate

endmodule

// File: rtl/sbs_arbiter.sv
module sbs_arbiter
    import sbs_pkg::*;
#(
    parameter int HANDLE_W = 8
) (
    input  logic                pool_open,
    input  logic                any_idle,
    input  logic                vtx_valid,
    input  logic [HANDLE_W-1:0] vtx_handle,
    input  logic                frg_valid,
    input  logic [HANDLE_W-1:0] frg_handle,
    output logic                vtx_ready,
    output logic                frg_ready,
    output logic                take,
    output batch_kind_e         take_kind,
    output logic [HANDLE_W-1:0] take_handle
);

    logic can_take;

    always_comb begin
        can_take  = pool_open && any_idle;
        vtx_ready = can_take;
        frg_ready = can_take && !vtx_valid;
        if (vtx_valid && vtx_ready) begin
            take        = 1'b1;
            take_kind   = KIND_VTX;
            take_handle = vtx_handle;
        end else if (frg_valid && frg_ready) begin
            take        = 1'b1;
            take_kind   = KIND_FRG;
            take_handle = frg_handle;
        end else begin
            take        = 1'b0;
            take_kind   = KIND_VTX;
            take_handle = '0;
        end
    end

    // R11: a single handshake per cycle
    always_comb begin
        one_take_chk: assert ($onehot0({vtx_valid && vtx_ready, frg_valid && frg_ready}));
    end

endmodule

// File: rtl/shader_batch_sched.sv
module shader_batch_sched
    import sbs_pkg::*;
#(
    parameter int NUM_PROC        = 4,
    parameter int PROC_PER_SLICE  = 2,
    parameter int HANDLE_W        = 8,
    parameter int VTX_PER_BATCH   = 16,
    parameter int QUADS_PER_BATCH = 4,
    parameter int PIX_PER_QUAD    = 4,
    localparam int IDX_W     = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
    localparam int NUM_SLICE = (NUM_PROC + PROC_PER_SLICE - 1) / PROC_PER_SLICE,
    localparam int SLICE_W   = (NUM_SLICE > 1) ? $clog2(NUM_SLICE) : 1,
    localparam int FRG_ITEMS = QUADS_PER_BATCH * PIX_PER_QUAD,
    localparam int MAX_ITEMS = (VTX_PER_BATCH > FRG_ITEMS) ? VTX_PER_BATCH : FRG_ITEMS,
    localparam int ITEM_W    = $clog2(MAX_ITEMS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vtx_valid,
    input  logic [HANDLE_W-1:0] vtx_handle,
    output logic                vtx_ready,
    input  logic                frg_valid,
    input  logic [HANDLE_W-1:0] frg_handle,
    output logic                frg_ready,
    input  logic [NUM_PROC-1:0] proc_done,
    output logic [NUM_PROC-1:0] proc_busy,
    output logic                asg_valid,
    output logic [IDX_W-1:0]    asg_proc,
    output logic [SLICE_W-1:0]  asg_slice,
    output logic                asg_kind,
    output logic [HANDLE_W-1:0] asg_handle,
    output logic [ITEM_W-1:0]   asg_items
);

    pool_state_e         state_q, state_d;
    logic                pool_open;
    logic [NUM_PROC-1:0] busy_q, busy_next, idle_vec, grant_vec;
    logic                any_idle;
    logic [IDX_W-1:0]    pick_idx;
    logic                take;
    batch_kind_e         take_kind;
    logic [HANDLE_W-1:0] take_handle;
    batch_kind_e         kind_q;

    assign idle_vec  = ~busy_q;
    assign proc_busy = busy_q;
    assign asg_kind  = kind_q;

    sbs_idle_pick #(.N(NUM_PROC), .IDX_W(IDX_W)) pick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .idle  (idle_vec),
        .found (any_idle),
        .idx   (pick_idx)
    );

    sbs_arbiter #(.HANDLE_W(HANDLE_W)) arb_i (
        .pool_open   (pool_open),
        .any_idle    (any_idle),
        .vtx_valid   (vtx_valid),
        .vtx_handle  (vtx_handle),
        .frg_valid   (frg_valid),
        .frg_handle  (frg_handle),
        .vtx_ready   (vtx_ready),
        .frg_ready   (frg_ready),
        .take        (take),
        .take_kind   (take_kind),
        .take_handle (take_handle)
    );

    assign grant_vec = take ? (NUM_PROC'(1) << pick_idx) : '0;

    sbs_busy_track #(.N(NUM_PROC)) busy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vec (grant_vec),
        .done_vec  (proc_done),
        .busy_q    (busy_q),
        .busy_next (busy_next)
    );

    // Pool controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= POOL_INIT;
        else
            state_q <= state_d;
    end

    // Pool controller: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POOL_INIT: state_d = POOL_OPEN;
            POOL_OPEN: if (&busy_next) state_d = POOL_FULL;
            POOL_FULL: if (!(&busy_next)) state_d = POOL_OPEN;
            default:   state_d = POOL_INIT;
        endcase
    end

    // Pool controller: outputs
    always_comb begin
        unique case (state_q)
            POOL_OPEN: pool_open = 1'b1;
            POOL_INIT,
            POOL_FULL: pool_open = 1'b0;
            default:   pool_open = 1'b0;
        endcase
    end

    // Assignment record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asg_valid  <= 1'b0;
            asg_proc   <= '0;
            asg_slice  <= '0;
            kind_q     <= KIND_VTX;
            asg_handle <= '0;
            asg_items  <= '0;
        end else begin
            asg_valid <= take;
            if (take) begin
                asg_proc   <= pick_idx;
                asg_slice  <= SLICE_W'(32'(pick_idx) / PROC_PER_SLICE);
                kind_q     <= take_kind;
                asg_handle <= take_handle;
                asg_items  <= (take_kind == KIND_VTX) ? ITEM_W'(VTX_PER_BATCH)
                                                      : ITEM_W'(FRG_ITEMS);
            end
        end
    end

    // R8
    busy_on_assign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid |-> busy_q[asg_proc]);

    // R4
    frg_after_no_vtx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asg_valid && kind_q == KIND_FRG) |-> $past(!vtx_valid));

    // R9
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_q) |-> (!vtx_ready && !frg_ready));

    // R1
    init_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == POOL_INIT) |-> (!vtx_ready && !frg_ready && !asg_valid));

endmodule

// File: tb/shader_batch_sched_tb.sv
module shader_batch_sched_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vtx_valid = 1'b0;
    logic [7:0] vtx_handle = '0;
    logic       vtx_ready;
    logic       frg_valid = 1'b0;
    logic [7:0] frg_handle = '0;
    logic       frg_ready;
    logic [3:0] proc_done = '0;
    logic [3:0] proc_busy;
    logic       asg_valid;
    logic [1:0] asg_proc;
    logic [0:0] asg_slice;
    logic       asg_kind;
    logic [7:0] asg_handle;
    logic [4:0] asg_items;

    int tests = 0;
    int fails = 0;
    bit over  = 1'b0;

    always #5 clk = ~clk;

    shader_batch_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .vtx_valid(vtx_valid), .vtx_handle(vtx_handle), .vtx_ready(vtx_ready),
        .frg_valid(frg_valid), .frg_handle(frg_handle), .frg_ready(frg_ready),
        .proc_done(proc_done), .proc_busy(proc_busy),
        .asg_valid(asg_valid), .asg_proc(asg_proc), .asg_slice(asg_slice),
        .asg_kind(asg_kind), .asg_handle(asg_handle), .asg_items(asg_items)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_asg(input string req, input int proc, input int slice,
                             input int kind, input int handle);
        check(req, "asg_valid", int'(asg_valid), 1);
        check(req, "asg_proc", int'(asg_proc), proc);
        check(req, "asg_slice", int'(asg_slice), slice);
        check(req, "asg_kind", int'(asg_kind), kind);
        check(req, "asg_handle", int'(asg_handle), handle);
        check("R6", "asg_items", int'(asg_items), 16);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(proc_busy), 0);
        check("R1", "asg_valid in reset", int'(asg_valid), 0);
        rst_n      = 1'b1;
        vtx_valid  = 1'b1;
        vtx_handle = 8'h11;
        #1;
        check("R1", "vtx_ready in init cycle", int'(vtx_ready), 0);
        check("R1", "frg_ready in init cycle", int'(frg_ready), 0);
        cycle();
        check("R1", "no assignment after init", int'(asg_valid), 0);
    endtask

    task automatic t_vertex_single();
        #1;
        check("R2", "vtx_ready open", int'(vtx_ready), 1);
        cycle();
        vtx_valid = 1'b0;
        check_asg("R2", 0, 0, 0, 8'h11);
        check("R8", "busy after first", int'(proc_busy), 4'b0001);
        cycle();
        check("R11", "asg_valid single cycle", int'(asg_valid), 0);
    endtask

    task automatic t_priority();
        vtx_valid  = 1'b1; vtx_handle = 8'h22;
        frg_valid  = 1'b1; frg_handle = 8'h99;
        #1;
        check("R3", "vtx_ready with both", int'(vtx_ready), 1);
        check("R3", "frg_ready with both", int'(frg_ready), 0);
        cycle();
        vtx_valid = 1'b0;
        check_asg("R3", 1, 0, 0, 8'h22);
        check("R8", "busy after vtx", int'(proc_busy), 4'b0011);
        #1;
        check("R4", "frg_ready without vtx", int'(frg_ready), 1);
        cycle();
        frg_valid = 1'b0;
        check_asg("R4", 2, 1, 1, 8'h99);
        check("R7", "slice of proc 2", int'(asg_slice), 1);
        check("R8", "busy after frg", int'(proc_busy), 4'b0111);
    endtask

    task automatic t_full();
        frg_valid = 1'b1; frg_handle = 8'h55;
        cycle();
        check_asg("R5", 3, 1, 1, 8'h55);
        check("R9", "busy all", int'(proc_busy), 4'b1111);
        frg_handle = 8'h66;
        vtx_valid  = 1'b1; vtx_handle = 8'h77;
        #1;
        check("R9", "vtx_ready when full", int'(vtx_ready), 0);
        check("R9", "frg_ready when full", int'(frg_ready), 0);
        cycle();
        check("R9", "no assignment when full", int'(asg_valid), 0);
        check("R9", "busy held", int'(proc_busy), 4'b1111);
    endtask

    task automatic t_release();
        proc_done = 4'b0101;
        #1;
        check("R10", "still blocked in done cycle", int'(vtx_ready), 0);
        cycle();
        proc_done = 4'b0000;
        check("R10", "busy after done", int'(proc_busy), 4'b1010);
        #1;
        check("R10", "vtx_ready after release", int'(vtx_ready), 1);
        check("R3", "frg_ready held back", int'(frg_ready), 0);
        cycle();
        vtx_valid = 1'b0;
        check_asg("R10", 0, 0, 0, 8'h77);
        check("R8", "busy after reuse", int'(proc_busy), 4'b1011);
        cycle();
        frg_valid = 1'b0;
        check_asg("R4", 2, 1, 1, 8'h66);
        check("R9", "busy refilled", int'(proc_busy), 4'b1111);
    endtask

    task automatic t_frag_order();
        proc_done = 4'b1111;
        cycle();
        proc_done = 4'b0000;
        check("R10", "all freed", int'(proc_busy), 0);
        proc_done = 4'b0001;
        cycle();
        proc_done = 4'b0000;
        check("R10", "done on idle ignored", int'(proc_busy), 0);
        check("R10", "no assignment from idle done", int'(asg_valid), 0);
        frg_valid = 1'b1; frg_handle = 8'hA0;
        cycle();
        check_asg("R5", 0, 0, 1, 8'hA0);
        frg_handle = 8'hA1;
        cycle();
        check_asg("R5", 1, 0, 1, 8'hA1);
        frg_handle = 8'hA2;
        cycle();
        frg_valid = 1'b0;
        check_asg("R5", 2, 1, 1, 8'hA2);
        check("R5", "busy after stream", int'(proc_busy), 4'b0111);
        cycle();
        check("R11", "stream ends", int'(asg_valid), 0);
    endtask

    initial begin
        t_reset();
        t_vertex_single();
        t_priority();
        t_full();
        t_release();
        t_frag_order();
        over = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule